// File: doc/BRIEF.md
# Multi-depth pixel fetch and palette

This block turns bytes read from video memory into two 12-bit RGB pixels per half-pixel tick; every clock cycle is one tick. The raster timer supplies horizontal and vertical display flags, a line-end pulse and a pulse that marks the first display line of a frame. While both display flags are high, the block issues byte reads from an address counter. That counter runs as a circular buffer between a programmable start and end, and it is reloaded from a frame start address once per frame. The fetched bytes wait in an eight-entry queue until the display window, delayed by a depth-dependent latency, reaches them.

The colour depth can be 1, 2, 4 or 8 bits per pixel. At the three lower depths each pixel indexes a 16-entry palette. At 8 bits per pixel the low nibble indexes the palette through a mask and the high nibble supplies direct colour bits. Outside the delayed window both pixels carry the border colour. A valid flag marks the ticks that carry picture data.

Top module: `pixel_fetch_palette`

## Requirements
- R1: The depth input encodes 0 as 1 bpp, 1 as 2 bpp, 2 as 4 bpp and 3 as 8 bpp. On a tick where h_disp and v_disp are both high, the block reads two bytes at 8 bpp (mem_rd0 and mem_rd1), one byte at 4 bpp, one byte on every second display tick of the line at 2 bpp, and one byte on every fourth display tick at 1 bpp. The first display tick of a line always fetches. No read is made when either flag is low.
- R2: Each byte read advances the fetch address by one. When the advanced address equals buf_end + 16, it becomes buf_start instead. At 8 bpp, mem_addr1 is the advanced form of mem_addr0.
- R3: A frame_load pulse loads the fetch address from frame_start, so the next read uses that address.
- R4: The queue write slot and the fetch tick count return to zero on line_end. Each line therefore starts filling at slot 0, whatever the previous line left behind.
- R5: With latency L equal to 9, 5, 3 and 2 ticks for 1, 2, 4 and 8 bpp, a tick is inside the output window when the display flags were both high L ticks earlier. Outside the window both pixels equal the border colour. Outputs are registered, so the result of a tick appears on the following clock.
- R6: At 4 bpp, output tick t of the line uses fetched byte t. pix0 takes the palette entry chosen by the low nibble and pix1 takes the entry chosen by the high nibble.
- R7: At 2 bpp, output tick t uses byte t/2, shifted right by 4*(t mod 2). pix0 takes the entry chosen by bits 1:0 and pix1 the entry chosen by bits 3:2. At 1 bpp, tick t uses byte t/4, shifted right by 2*(t mod 4). pix0 takes the entry chosen by bit 0 and pix1 the entry chosen by bit 1.
- R8: Colours are {blue[11:8], green[7:4], red[3:0]}. At 8 bpp, output tick t uses bytes 2t (pix0) and 2t+1 (pix1). Each pixel is the palette entry at the low nibble ANDed with 12'h737, ORed with byte bit 7 in colour bit 11, bit 6 in bit 7, bit 5 in bit 6 and bit 4 in bit 3.
- R9: A palette or border write is first used by the tick after the write cycle, so its effect reaches the pixel outputs two clocks after the write edge.
- R10: pix_valid is high exactly for the output ticks inside the window of R5, and it is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| h_disp | input | 1 | Horizontal display active |
| v_disp | input | 1 | Vertical display active |
| line_end | input | 1 | End-of-line pulse |
| frame_load | input | 1 | First display line pulse, loads frame_start |
| depth | input | 2 | Colour depth code |
| frame_start | input | AW | Frame start address |
| buf_start | input | AW | Circular buffer start address |
| buf_end | input | AW | Circular buffer end address |
| mem_rd0 | output | 1 | First byte read this tick |
| mem_addr0 | output | AW | First byte address |
| mem_data0 | input | 8 | First byte data, same cycle |
| mem_rd1 | output | 1 | Second byte read this tick (8 bpp) |
| mem_addr1 | output | AW | Second byte address |
| mem_data1 | input | 8 | Second byte data, same cycle |
| pal_we | input | 1 | Palette write strobe |
| pal_idx | input | PIW | Palette entry index |
| pal_data | input | 12 | Palette entry colour |
| border_we | input | 1 | Border write strobe |
| border_data | input | 12 | Border colour |
| pix0 | output | 12 | First pixel of the pair |
| pix1 | output | 12 | Second pixel of the pair |
| pix_valid | output | 1 | Pair holds picture data |

## Verification
The assertions check four properties on every cycle: the sparse fetch spacing at 1 and 2 bpp, the address only stepping forward or jumping to the buffer start, the load from frame_start, and the clearing of the write slot and tick count at each line end. Only the bench scenarios can show the depth-dependent window latency, the nibble and bit order of each depth, the 8 bpp mask and direct-bit mixing, the wrap at buffer end plus 16 in the middle of an 8 bpp pair, and the one-tick delay before a border write takes effect. The bench checks these against a byte stream it models from the memory contents and the address rules.

// File: rtl/pfp_pkg.sv
package pfp_pkg;

    typedef enum logic [1:0] {
        DEPTH_1BPP = 2'd0,
        DEPTH_2BPP = 2'd1,
        DEPTH_4BPP = 2'd2,
        DEPTH_8BPP = 2'd3
    } depth_e;

    // Longest window delay over all depths
    localparam int unsigned LAT_MAX = 9;

    // Palette bits kept at 8 bpp
    localparam logic [11:0] PAL_MASK_8BPP = 12'h737;

    function automatic int unsigned out_latency(depth_e d);
        case (d)
            DEPTH_1BPP: return 9;
            DEPTH_2BPP: return 5;
            DEPTH_4BPP: return 3;
            default:    return 2;
        endcase
    endfunction

    // Direct colour bits from the upper nibble of an 8 bpp byte
    function automatic logic [11:0] direct_bits(logic [3:0] hi);
        return {hi[3], 3'b000, hi[2], hi[1], 2'b00, hi[0], 3'b000};
    endfunction

endpackage

// File: rtl/pfp_addr.sv
module pfp_addr
    import pfp_pkg::*;
#(
    parameter int AW     = 16,
    parameter int QDEPTH = 8,
    localparam int QW    = $clog2(QDEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          disp,
    input  logic          line_end,
    input  logic          frame_load,
    input  depth_e        depth,
    input  logic [AW-1:0] frame_start,
    input  logic [AW-1:0] buf_start,
    input  logic [AW-1:0] buf_end,
    output logic          rd0,
    output logic          rd1,
    output logic [AW-1:0] addr0,
    output logic [AW-1:0] addr1,
    output logic [QW-1:0] wr_idx0,
    output logic [QW-1:0] wr_idx1
);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [1:0]    fc;
        logic [QW-1:0] wptr;
    } st_t;

    st_t st_d, st_q;
    logic [AW-1:0] wrap_at, step1, step2;

    function automatic logic [AW-1:0] advance(logic [AW-1:0] a, logic [AW-1:0] lim,
                                              logic [AW-1:0] base);
        logic [AW-1:0] n;
        n = a + AW'(1);
        return (n == lim) ? base : n;
    endfunction

    always_comb begin
        wrap_at = buf_end + AW'(16);
        step1   = advance(st_q.addr, wrap_at, buf_start);
        step2   = advance(step1, wrap_at, buf_start);

        case (depth)
            DEPTH_8BPP, DEPTH_4BPP: rd0 = disp;
            DEPTH_2BPP:             rd0 = disp && !st_q.fc[0];
            default:                rd0 = disp && (st_q.fc == 2'd0);
        endcase
        rd1 = disp && (depth == DEPTH_8BPP);

        st_d = st_q;
        if (disp) st_d.fc = st_q.fc + 2'd1;
        if (rd1) begin
            st_d.addr = step2;
            st_d.wptr = st_q.wptr + QW'(2);
        end else if (rd0) begin
            st_d.addr = step1;
            st_d.wptr = st_q.wptr + QW'(1);
        end
        if (frame_load) st_d.addr = frame_start;
        if (line_end) begin
            st_d.fc   = '0;
            st_d.wptr = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr0   = st_q.addr;
    assign addr1   = step1;
    assign wr_idx0 = st_q.wptr;
    assign wr_idx1 = st_q.wptr + QW'(1);

    // R1: a sparse-depth fetch is never followed by another on the next tick
    assert_sparse_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0 && !line_end && (depth == DEPTH_1BPP || depth == DEPTH_2BPP))
        |=> (!rd0 || !$stable(depth)));

    // R2: after a read the address steps forward or restarts at the buffer start
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0 && !frame_load) |=>
        (st_q.addr == $past(st_q.addr) + AW'(1) || st_q.addr == $past(st_q.addr) + AW'(2) ||
         st_q.addr == $past(buf_start) || st_q.addr == $past(buf_start) + AW'(1)));

    // R3: a frame load takes the frame start address
    assert_frame_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_load |=> (st_q.addr == $past(frame_start)));

    // R4: line end restarts the queue fill and the fetch phase
    assert_line_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> (st_q.wptr == '0 && st_q.fc == 2'd0));

endmodule

// File: rtl/pfp_queue.sv
module pfp_queue
    import pfp_pkg::*;
#(
    parameter int QDEPTH = 8,
    localparam int QW    = $clog2(QDEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  depth_e        depth,
    input  logic          win,
    input  logic          line_end,
    input  logic          wr0,
    input  logic          wr1,
    input  logic [QW-1:0] wr_idx0,
    input  logic [QW-1:0] wr_idx1,
    input  logic [7:0]    wdata0,
    input  logic [7:0]    wdata1,
    output logic [7:0]    byte0,
    output logic [7:0]    byte1
);

    typedef struct packed {
        logic [QDEPTH-1:0][7:0] q;
        logic [QW+1:0]          oc;
    } st_t;

    st_t st_d, st_q;
    logic [QW-1:0] idx0, idx1;

    always_comb begin
        case (depth)
            DEPTH_8BPP: idx0 = {st_q.oc[QW-2:0], 1'b0};
            DEPTH_4BPP: idx0 = st_q.oc[QW-1:0];
            DEPTH_2BPP: idx0 = st_q.oc[QW:1];
            default:    idx0 = st_q.oc[QW+1:2];
        endcase
        idx1 = idx0 | QW'(1);

        st_d = st_q;
        if (win) begin
            st_d.oc = st_q.oc + 1'b1;
            if (depth == DEPTH_2BPP) st_d.q[idx0] = st_q.q[idx0] >> 4;
            if (depth == DEPTH_1BPP) st_d.q[idx0] = st_q.q[idx0] >> 2;
        end
        if (wr0) st_d.q[wr_idx0] = wdata0;
        if (wr1) st_d.q[wr_idx1] = wdata1;
        if (line_end) st_d.oc = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign byte0 = st_q.q[idx0];
    assign byte1 = st_q.q[idx1];

endmodule

// File: rtl/pfp_window.sv
module pfp_window
    import pfp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   disp,
    input  depth_e depth,
    output logic   win
);

    logic [LAT_MAX-1:0] dly_d, dly_q;

    always_comb begin
        dly_d = {dly_q[LAT_MAX-2:0], disp};
        win   = dly_q[out_latency(depth) - 1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dly_q <= '0;
        else        dly_q <= dly_d;
    end

endmodule

// File: rtl/pfp_render.sv
module pfp_render
    import pfp_pkg::*;
#(
    parameter int NPAL    = 16,
    localparam int PIW    = $clog2(NPAL)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  depth_e         depth,
    input  logic           win,
    input  logic [7:0]     byte0,
    input  logic [7:0]     byte1,
    input  logic           pal_we,
    input  logic [PIW-1:0] pal_idx,
    input  logic [11:0]    pal_data,
    input  logic           border_we,
    input  logic [11:0]    border_data,
    output logic [11:0]    pix0,
    output logic [11:0]    pix1,
    output logic           pix_valid
);

    typedef struct packed {
        logic [NPAL-1:0][11:0] pal;
        logic [11:0]           border;
        logic [11:0]           p0;
        logic [11:0]           p1;
        logic                  valid;
    } st_t;

    st_t st_d, st_q;
    logic [11:0] c0, c1;

    always_comb begin
        case (depth)
            DEPTH_8BPP: begin
                c0 = (st_q.pal[PIW'(byte0[3:0])] & PAL_MASK_8BPP) | direct_bits(byte0[7:4]);
                c1 = (st_q.pal[PIW'(byte1[3:0])] & PAL_MASK_8BPP) | direct_bits(byte1[7:4]);
            end
            DEPTH_4BPP: begin
                c0 = st_q.pal[PIW'(byte0[3:0])];
                c1 = st_q.pal[PIW'(byte0[7:4])];
            end
            DEPTH_2BPP: begin
                c0 = st_q.pal[PIW'(byte0[1:0])];
                c1 = st_q.pal[PIW'(byte0[3:2])];
            end
            default: begin
                c0 = st_q.pal[PIW'(byte0[0])];
                c1 = st_q.pal[PIW'(byte0[1])];
            end
        endcase

        st_d       = st_q;
        st_d.valid = win;
        st_d.p0    = win ? c0 : st_q.border;
        st_d.p1    = win ? c1 : st_q.border;
        if (pal_we)    st_d.pal[pal_idx] = pal_data;
        if (border_we) st_d.border       = border_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pix0      = st_q.p0;
    assign pix1      = st_q.p1;
    assign pix_valid = st_q.valid;

endmodule

// File: rtl/pixel_fetch_palette.sv
module pixel_fetch_palette
    import pfp_pkg::*;
#(
    parameter int AW      = 16,
    parameter int QDEPTH  = 8,
    parameter int NPAL    = 16,
    localparam int PIW    = $clog2(NPAL),
    localparam int QW     = $clog2(QDEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           h_disp,
    input  logic           v_disp,
    input  logic           line_end,
    input  logic           frame_load,
    input  logic [1:0]     depth,
    input  logic [AW-1:0]  frame_start,
    input  logic [AW-1:0]  buf_start,
    input  logic [AW-1:0]  buf_end,
    output logic           mem_rd0,
    output logic [AW-1:0]  mem_addr0,
    input  logic [7:0]     mem_data0,
    output logic           mem_rd1,
    output logic [AW-1:0]  mem_addr1,
    input  logic [7:0]     mem_data1,
    input  logic           pal_we,
    input  logic [PIW-1:0] pal_idx,
    input  logic [11:0]    pal_data,
    input  logic           border_we,
    input  logic [11:0]    border_data,
    output logic [11:0]    pix0,
    output logic [11:0]    pix1,
    output logic           pix_valid
);

    depth_e        dep;
    logic          disp, win;
    logic [QW-1:0] wr_idx0, wr_idx1;
    logic [7:0]    byte0, byte1;

    assign dep  = depth_e'(depth);
    assign disp = h_disp & v_disp;

    pfp_addr #(.AW(AW), .QDEPTH(QDEPTH)) u_addr (
        .clk(clk), .rst_n(rst_n), .disp(disp), .line_end(line_end),
        .frame_load(frame_load), .depth(dep), .frame_start(frame_start),
        .buf_start(buf_start), .buf_end(buf_end),
        .rd0(mem_rd0), .rd1(mem_rd1), .addr0(mem_addr0), .addr1(mem_addr1),
        .wr_idx0(wr_idx0), .wr_idx1(wr_idx1)
    );

    pfp_window u_window (
        .clk(clk), .rst_n(rst_n), .disp(disp), .depth(dep), .win(win)
    );

    pfp_queue #(.QDEPTH(QDEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .depth(dep), .win(win), .line_end(line_end),
        .wr0(mem_rd0), .wr1(mem_rd1), .wr_idx0(wr_idx0), .wr_idx1(wr_idx1),
        .wdata0(mem_data0), .wdata1(mem_data1), .byte0(byte0), .byte1(byte1)
    );

    pfp_render #(.NPAL(NPAL)) u_render (
        .clk(clk), .rst_n(rst_n), .depth(dep), .win(win),
        .byte0(byte0), .byte1(byte1),
        .pal_we(pal_we), .pal_idx(pal_idx), .pal_data(pal_data),
        .border_we(border_we), .border_data(border_data),
        .pix0(pix0), .pix1(pix1), .pix_valid(pix_valid)
    );

endmodule

// File: tb/pixel_fetch_palette_tb.sv
`timescale 1ns/1ps
module pixel_fetch_palette_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_disp = 1'b0, v_disp = 1'b0, line_end = 1'b0, frame_load = 1'b0;
    logic [1:0]  depth = 2'd2;
    logic [15:0] frame_start = '0, buf_start = '0, buf_end = '0;
    logic        mem_rd0, mem_rd1;
    logic [15:0] mem_addr0, mem_addr1;
    logic [7:0]  mem_data0, mem_data1;
    logic        pal_we = 1'b0, border_we = 1'b0;
    logic [3:0]  pal_idx = '0;
    logic [11:0] pal_data = '0, border_data = '0;
    logic [11:0] pix0, pix1;
    logic        pix_valid;

    always #2.5 clk = ~clk;

    function automatic logic [7:0] mbyte(input logic [15:0] a);
        logic [15:0] m;
        m = a * 16'd37 + 16'd11;
        return m[7:0] ^ a[15:8];
    endfunction

    assign mem_data0 = mbyte(mem_addr0);
    assign mem_data1 = mbyte(mem_addr1);

    pixel_fetch_palette u_dut (
        .clk(clk), .rst_n(rst_n), .h_disp(h_disp), .v_disp(v_disp),
        .line_end(line_end), .frame_load(frame_load), .depth(depth),
        .frame_start(frame_start), .buf_start(buf_start), .buf_end(buf_end),
        .mem_rd0(mem_rd0), .mem_addr0(mem_addr0), .mem_data0(mem_data0),
        .mem_rd1(mem_rd1), .mem_addr1(mem_addr1), .mem_data1(mem_data1),
        .pal_we(pal_we), .pal_idx(pal_idx), .pal_data(pal_data),
        .border_we(border_we), .border_data(border_data),
        .pix0(pix0), .pix1(pix1), .pix_valid(pix_valid)
    );

    // Stimulus table: depth, display ticks, load flag, frame start,
    // buffer start, buffer end, expected bytes read on the line
    typedef struct packed {
        logic [1:0]  dep;
        logic [7:0]  len;
        logic        ld;
        logic [15:0] fs;
        logic [15:0] bs;
        logic [15:0] be;
        logic [7:0]  nb;
    } vec_t;

    localparam int N_VEC = 7;
    localparam vec_t VEC [N_VEC] = '{
        '{2'd2, 8'd6, 1'b1, 16'h0100, 16'h0100, 16'h0200, 8'd6},
        '{2'd2, 8'd5, 1'b0, 16'h0000, 16'h0100, 16'h0200, 8'd5},
        '{2'd3, 8'd6, 1'b1, 16'h0200, 16'h0100, 16'h0400, 8'd12},
        '{2'd1, 8'd7, 1'b1, 16'h0300, 16'h0100, 16'h0400, 8'd4},
        '{2'd0, 8'd9, 1'b1, 16'h0400, 16'h0100, 16'h0500, 8'd3},
        '{2'd3, 8'd5, 1'b1, 16'h200B, 16'h1000, 16'h2000, 8'd10},
        '{2'd2, 8'd8, 1'b1, 16'h300C, 16'h0500, 16'h3000, 8'd8}
    };

    int          checks = 0, errors = 0;
    logic        done = 1'b0;
    logic [11:0] pal_m [16];
    logic [11:0] border_m = '0;
    logic [15:0] mdl_addr = '0;
    logic [7:0]  lb [64];
    int          nlb;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int lat_of(input int d);
        case (d)
            0: return 9;
            1: return 5;
            2: return 3;
            default: return 2;
        endcase
    endfunction

    function automatic logic [15:0] step_m(input logic [15:0] a, input logic [15:0] bs,
                                           input logic [15:0] be);
        logic [15:0] n;
        n = a + 16'd1;
        return (n == be + 16'd16) ? bs : n;
    endfunction

    function automatic logic [11:0] mix8(input logic [7:0] b);
        return (pal_m[b[3:0]] & 12'h737) |
               {b[7], 3'b000, b[6], b[5], 2'b00, b[4], 3'b000};
    endfunction

    task automatic exp_pix(input int t, input int d, output logic [11:0] e0,
                           output logic [11:0] e1);
        logic [7:0] x;
        case (d)
            3: begin e0 = mix8(lb[2*t]); e1 = mix8(lb[2*t+1]); end
            2: begin x = lb[t]; e0 = pal_m[x[3:0]]; e1 = pal_m[x[7:4]]; end
            1: begin
                x = lb[t/2] >> (4*(t%2));
                e0 = pal_m[{2'b00, x[1:0]}]; e1 = pal_m[{2'b00, x[3:2]}];
            end
            default: begin
                x = lb[t/4] >> (2*(t%4));
                e0 = pal_m[{3'b000, x[0]}]; e1 = pal_m[{3'b000, x[1]}];
            end
        endcase
    endtask

    task automatic write_pal(input int i, input logic [11:0] v);
        @(negedge clk);
        pal_we = 1'b1; pal_idx = 4'(i); pal_data = v;
        @(negedge clk);
        pal_we = 1'b0;
        pal_m[i] = v;
    endtask

    task automatic run_line(input vec_t v);
        int L, pre, total, len, d, nf;
        logic [11:0] e0, e1;
        string tag;
        @(negedge clk);
        depth = v.dep; buf_start = v.bs; buf_end = v.be; frame_start = v.fs;
        if (v.ld) begin
            frame_load = 1'b1;
            @(negedge clk);
            frame_load = 1'b0;
            mdl_addr = v.fs;
        end
        d = int'(v.dep); len = int'(v.len); L = lat_of(d); pre = 2;
        total = pre + len + 14; nlb = 0; nf = 0;
        for (int c = 0; c < total; c++) begin
            @(negedge clk);
            if (c >= 1) begin
                int t;
                bit w;
                t = c - 1 - L - pre;
                w = (t >= 0) && (t < len);
                if (w) begin
                    exp_pix(t, d, e0, e1);
                    if (!v.ld)      tag = "R4";
                    else if (d == 3) tag = "R8";
                    else if (d == 2) tag = "R6";
                    else            tag = "R7";
                end else begin
                    e0 = border_m; e1 = border_m; tag = "R5";
                end
                check(pix_valid == w && pix0 == e0 && pix1 == e1,
                      w ? tag : "R10", "valid/pix0/pix1",
                      {7'd0, pix_valid, pix0, pix1}, {7'd0, w, e0, e1});
            end
            h_disp = (c >= pre) && (c < pre + len);
            v_disp = h_disp;
            #1;
            if (h_disp) begin
                int f;
                bit er0, er1;
                f = c - pre;
                er0 = (d >= 2) || (d == 1 && f % 2 == 0) || (d == 0 && f % 4 == 0);
                er1 = (d == 3);
                check(mem_rd0 == er0 && mem_rd1 == er1, "R1", "read strobes",
                      {30'd0, mem_rd1, mem_rd0}, {30'd0, er1, er0});
                if (er0) begin
                    check(mem_addr0 == mdl_addr, (v.ld && nlb == 0) ? "R3" : "R2",
                          "addr0", {16'd0, mem_addr0}, {16'd0, mdl_addr});
                    lb[nlb] = mbyte(mdl_addr); nlb++;
                    mdl_addr = step_m(mdl_addr, v.bs, v.be);
                end
                if (er1) begin
                    check(mem_addr1 == mdl_addr, "R2", "addr1",
                          {16'd0, mem_addr1}, {16'd0, mdl_addr});
                    lb[nlb] = mbyte(mdl_addr); nlb++;
                    mdl_addr = step_m(mdl_addr, v.bs, v.be);
                end
            end
            nf += int'(mem_rd0) + int'(mem_rd1);
        end
        @(negedge clk);
        line_end = 1'b1;
        @(negedge clk);
        line_end = 1'b0;
        check(nf == int'(v.nb), "R1", "bytes read on line", nf, int'(v.nb));
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) pal_m[i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check(pix_valid == 1'b0, "R10", "valid after reset", pix_valid, 0);
        check(pix0 == 12'h000 && pix1 == 12'h000, "R5", "border after reset",
              {pix0, pix1}, 0);
        check(mem_rd0 == 1'b0 && mem_rd1 == 1'b0, "R1", "idle reads", {mem_rd1, mem_rd0}, 0);

        // Border write: unseen one clock after the write edge, seen after two (R9)
        border_we = 1'b1; border_data = 12'hABC;
        @(negedge clk);
        border_we = 1'b0;
        check(pix0 == 12'h000, "R9", "border before use", pix0, 12'h000);
        @(negedge clk);
        check(pix0 == 12'hABC && pix1 == 12'hABC, "R9", "border after use",
              {pix0, pix1}, {12'hABC, 12'hABC});
        border_m = 12'hABC;

        for (int i = 0; i < 16; i++) write_pal(i, 12'((i * 419) ^ 12'h5C6));

        // Horizontal display without vertical display fetches nothing (R1)
        depth = 2'd2;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            h_disp = 1'b1; v_disp = 1'b0;
            #1;
            check(mem_rd0 == 1'b0, "R1", "read without vertical display", mem_rd0, 0);
        end
        @(negedge clk);
        h_disp = 1'b0;
        for (int c = 0; c < 12; c++) begin
            @(negedge clk);
            check(pix_valid == 1'b0 && pix0 == border_m, "R5", "border when gated",
                  {pix_valid, pix0}, {1'b0, border_m});
        end
        line_end = 1'b1;
        @(negedge clk);
        line_end = 1'b0;

        for (int k = 0; k < N_VEC; k++) begin
            if (k == 5) for (int i = 0; i < 16; i++) write_pal(i, 12'((i * 1187) ^ 12'h29B));
            run_line(VEC[k]);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule